// File: doc/BRIEF.md
# Boot-overlay memory map decoder

This block sorts every processor access into one of four destinations: the local fast RAM, the register window of the disk controller, the boot ROM image, or the external system bus. The decision is combinational from the address, the access size and the direction. A single stored bit, the overlay state, chooses where the 512 KiB ROM image appears. Out of reset the image is mirrored at address zero, so the processor can fetch its reset vectors. Once software clears the bit, the image sits only near the top of the 24-bit space.

The overlay state is a two-state machine. `OVL_BOOT_MIRROR` is entered on reset and through the `SET_MIRROR` transition. `OVL_ROM_HIGH` is entered through the `CLEAR_MIRROR` transition. Both transitions are caused by a byte write to address 0xBFE001, and the new state is taken from bit 0 of the written byte. The state changes on the clock edge that ends the write. The same write is still routed to the external bus, because the peripheral that owns that address must also see it.

Each select comes with an offset into the chosen target. An access that no region claims raises no select. When such an access is a read, the block raises a flag telling the bus logic to return all ones.

Top module: `boot_map_decoder`

## Requirements
- R1: After reset is asserted, the overlay state is `OVL_BOOT_MIRROR` (`overlay_on` = 1).
- R2: Only a byte write (`req_size` = 0) to address 0xBFE001 changes the overlay state, to the value of `req_wdata[0]`, and the new state appears one clock later. Word (`req_size` = 1) and long (`req_size` = 2) writes to that address, and every other access, leave the state unchanged.
- R3: A write to 0xBFE001 selects the external bus, with the address as the offset.
- R4: When the overlay is on, a read of an address below 0x07FFFF selects ROM, and the offset equals the address. The address 0x07FFFF itself is not in this range.
- R5: When the overlay is off, a read from 0xF80000 up to 0xFFFFFE selects ROM, and the offset is the address minus 0xF80000. Low addresses then go to the external bus.
- R6: An address strictly between 0xD80000 and 0xDEFFFF selects the controller window, and the offset is the address minus 0xD80000. The two bounds themselves fall to the external bus.
- R7: An address strictly above 0x07FFFFFF selects fast RAM, and the offset is the address minus 0x07FFFFFF.
- R8: The checks run in this priority order: controller window, fast RAM, ROM, external bus. The external bus takes any address below 0xFFFFFF that no earlier region claims. At most one select is active.
- R9: A write never selects ROM. A write that falls in a ROM range goes to the external bus instead.
- R10: An access that matches no region raises no select and gives an offset of 0. `fill_ones` is raised only when that access is a read.
- R11: With `req_valid` low, no select and no `fill_ones` are raised, and the offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the overlay state |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access is present this cycle |
| req_addr | input | 32 | Byte address of the access |
| req_size | input | 2 | 0 = byte, 1 = word, 2 = long |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Written byte; bit 0 loads the overlay state |
| sel_ctl | output | 1 | Controller register window selected |
| sel_ram | output | 1 | Fast RAM selected |
| sel_rom | output | 1 | Boot ROM selected |
| sel_ext | output | 1 | External bus selected |
| fill_ones | output | 1 | Unclaimed read; return all ones |
| region_off | output | 32 | Offset into the selected target |
| overlay_on | output | 1 | 1 while the ROM is mirrored at zero |

## Verification
Some properties are checked by assertions on every cycle: at most one select is active, ROM is never chosen for a write, an idle cycle raises nothing, `fill_ones` never appears on a write, and the overlay state changes only one clock after a byte write to the overlay address and otherwise holds. Other behaviours can only be shown by the bench's scenarios. These are the exact window bounds (0x07FFFF, 0xF80000, 0xFFFFFF, and both controller edges), the offset values, the priority when ranges overlap, and the movement of the ROM image after the overlay changes. The bench compares all of these against its own model on every access.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_e;

    typedef enum logic {
        OVL_ROM_HIGH    = 1'b0,
        OVL_BOOT_MIRROR = 1'b1
    } ovl_state_e;

    // index order is the decode priority, lowest index wins
    typedef enum logic [1:0] {
        RG_CTL = 2'd0,
        RG_RAM = 2'd1,
        RG_ROM = 2'd2,
        RG_EXT = 2'd3
    } region_e;

    localparam int unsigned N_REGIONS = 4;

endpackage

// File: rtl/overlay_fsm.sv
module overlay_fsm
    import boot_map_pkg::*;
#(
    parameter int unsigned          ADDR_W   = 32,
    parameter logic [ADDR_W-1:0]    CTRL_ADR = 32'h00BF_E001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wbit,
    output ovl_state_e        state
);

    ovl_state_e state_nx;
    logic       ctl_wr;

    assign ctl_wr = req_valid && req_write &&
                    (req_size == SZ_BYTE) && (req_addr == CTRL_ADR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OVL_BOOT_MIRROR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OVL_BOOT_MIRROR: if (ctl_wr && !wbit) state_nx = OVL_ROM_HIGH;    // CLEAR_MIRROR
            OVL_ROM_HIGH:    if (ctl_wr &&  wbit) state_nx = OVL_BOOT_MIRROR; // SET_MIRROR
            default:         state_nx = OVL_BOOT_MIRROR;
        endcase
    end

endmodule

// File: rtl/window_match.sv
module window_match
    import boot_map_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       ROM_BYTES = 524288,
    parameter logic [ADDR_W-1:0] CTL_BASE  = 32'h00D8_0000,
    parameter logic [ADDR_W-1:0] CTL_SPAN  = 32'h0006_FFFF,
    parameter logic [ADDR_W-1:0] RAM_BASE  = 32'h07FF_FFFF,
    parameter logic [ADDR_W-1:0] BUS_LIMIT = 32'h00FF_FFFF
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  ovl_state_e        ovl,
    output logic [N_REGIONS-1:0] hit,
    output logic [ADDR_W-1:0]    off [N_REGIONS]
);

    localparam logic [ADDR_W-1:0] ROM_SZ      = ADDR_W'(ROM_BYTES);
    localparam logic [ADDR_W-1:0] ROM_LOW_END = ROM_SZ - 1'b1;
    localparam logic [ADDR_W-1:0] ROM_HI_BASE = BUS_LIMIT + 1'b1 - ROM_SZ;
    localparam logic [ADDR_W-1:0] CTL_END     = CTL_BASE + CTL_SPAN;

    logic rom_low, rom_high;

    assign rom_low  = (ovl == OVL_BOOT_MIRROR) && (req_addr < ROM_LOW_END);
    assign rom_high = (ovl == OVL_ROM_HIGH) &&
                      (req_addr >= ROM_HI_BASE) && (req_addr < BUS_LIMIT);

    always_comb begin
        hit         = '0;
        hit[RG_CTL] = req_valid && (req_addr > CTL_BASE) && (req_addr < CTL_END);
        hit[RG_RAM] = req_valid && (req_addr > RAM_BASE);
        hit[RG_ROM] = req_valid && !req_write && (rom_low || rom_high);
        hit[RG_EXT] = req_valid && (req_addr < BUS_LIMIT);
    end

    always_comb begin
        off[RG_CTL] = req_addr - CTL_BASE;
        off[RG_RAM] = req_addr - RAM_BASE;
        off[RG_ROM] = (ovl == OVL_BOOT_MIRROR) ? req_addr : (req_addr - ROM_HI_BASE);
        off[RG_EXT] = req_addr;
    end

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_lvl
            if (i == 0) begin : g_first
                assign gnt[i] = req[i];
            end else begin : g_rest
                assign gnt[i] = req[i] && !(|req[i-1:0]);
            end
        end
    endgenerate

endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder
    import boot_map_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       ROM_BYTES = 524288,
    parameter logic [ADDR_W-1:0] CTL_BASE  = 32'h00D8_0000,
    parameter logic [ADDR_W-1:0] CTL_SPAN  = 32'h0006_FFFF,
    parameter logic [ADDR_W-1:0] RAM_BASE  = 32'h07FF_FFFF,
    parameter logic [ADDR_W-1:0] BUS_LIMIT = 32'h00FF_FFFF,
    parameter logic [ADDR_W-1:0] CTRL_ADR  = 32'h00BF_E001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [7:0]        req_wdata,
    output logic              sel_ctl,
    output logic              sel_ram,
    output logic              sel_rom,
    output logic              sel_ext,
    output logic              fill_ones,
    output logic [ADDR_W-1:0] region_off,
    output logic              overlay_on
);

    ovl_state_e           ovl;
    logic [N_REGIONS-1:0] hit;
    logic [N_REGIONS-1:0] gnt;
    logic [ADDR_W-1:0]    off [N_REGIONS];

    overlay_fsm #(.ADDR_W(ADDR_W), .CTRL_ADR(CTRL_ADR)) u_ovl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .wbit      (req_wdata[0]),
        .state     (ovl)
    );

    window_match #(
        .ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES), .CTL_BASE(CTL_BASE),
        .CTL_SPAN(CTL_SPAN), .RAM_BASE(RAM_BASE), .BUS_LIMIT(BUS_LIMIT)
    ) u_win (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .ovl       (ovl),
        .hit       (hit),
        .off       (off)
    );

    prio_pick #(.N(N_REGIONS)) u_pick (
        .req (hit),
        .gnt (gnt)
    );

    always_comb begin
        region_off = '0;
        for (int k = 0; k < N_REGIONS; k++) begin
            if (gnt[k]) region_off = region_off | off[k];
        end
    end

    assign sel_ctl    = gnt[RG_CTL];
    assign sel_ram    = gnt[RG_RAM];
    assign sel_rom    = gnt[RG_ROM];
    assign sel_ext    = gnt[RG_EXT];
    assign fill_ones  = req_valid && !req_write && !(|gnt);
    assign overlay_on = (ovl == OVL_BOOT_MIRROR);

endmodule

// File: rtl/boot_map_chk.sv
module boot_map_chk #(
    parameter int unsigned       ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RAM_BASE = 32'h07FF_FFFF,
    parameter logic [ADDR_W-1:0] CTRL_ADR = 32'h00BF_E001
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              req_write,
    input logic [7:0]        req_wdata,
    input logic              sel_ctl,
    input logic              sel_ram,
    input logic              sel_rom,
    input logic              sel_ext,
    input logic              fill_ones,
    input logic [ADDR_W-1:0] region_off,
    input logic              overlay_on
);

    logic ovl_wr;
    assign ovl_wr = req_valid && req_write && (req_size == 2'd0) && (req_addr == CTRL_ADR);

    // R1
    ovl_reset_chk: assert property (@(posedge clk) !rst_n |=> overlay_on);

    // R2
    ovl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_wr |=> (overlay_on == $past(req_wdata[0])));

    // R2
    ovl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_wr |=> $stable(overlay_on));

    // R8
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ctl, sel_ram, sel_rom, sel_ext}));

    // R9
    rom_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> !sel_rom);

    // R7
    ram_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr > RAM_BASE)) |-> (sel_ram && region_off == req_addr - RAM_BASE));

    // R10
    fill_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ones |-> (!req_write && !sel_ctl && !sel_ram && !sel_rom && !sel_ext));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> ($countones({sel_ctl, sel_ram, sel_rom, sel_ext, fill_ones}) == 0));

endmodule

bind boot_map_decoder boot_map_chk #(
    .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .CTRL_ADR(CTRL_ADR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .sel_ctl(sel_ctl), .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_ext(sel_ext),
    .fill_ones(fill_ones), .region_off(region_off), .overlay_on(overlay_on)
);

// File: tb/sim_boot_map_decoder.sv
module sim_boot_map_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        sel_ctl, sel_ram, sel_rom, sel_ext, fill_ones, overlay_on;
    logic [31:0] region_off;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;
    bit m_ovl  = 1'b1;

    always #10 clk = ~clk;

    boot_map_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .sel_ctl(sel_ctl), .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_ext(sel_ext),
        .fill_ones(fill_ones), .region_off(region_off), .overlay_on(overlay_on)
    );

    // reference overlay bit
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_ovl <= 1'b1;
        else if (req_valid && req_write && req_size == 2'd0 && req_addr == 32'hBFE001)
            m_ovl <= req_wdata[0];
    end

    function automatic logic [37:0] expect_out();
        longint unsigned a = longint'(req_addr);
        logic [3:0] s = 4'b0;   // {ctl,ram,rom,ext}
        longint unsigned o = 0;
        bit f = 0;
        if (req_valid) begin
            if (a > 64'hD80000 && a < 64'hD80000 + 64'h6FFFF) begin s = 4'b1000; o = a - 64'hD80000; end
            else if (a > 64'h07FFFFFF) begin s = 4'b0100; o = a - 64'h07FFFFFF; end
            else if (!req_write && m_ovl && a < 64'h7FFFF) begin s = 4'b0010; o = a; end
            else if (!req_write && !m_ovl && a >= 64'hF80000 && a < 64'hFFFFFF) begin s = 4'b0010; o = a - 64'hF80000; end
            else if (a < 64'hFFFFFF) begin s = 4'b0001; o = a; end
            else f = !req_write;
        end
        return {s, f, o[31:0], m_ovl};
    endfunction

    task automatic compare(string tag);
        logic [37:0] act, exp_v;
        act   = {sel_ctl, sel_ram, sel_rom, sel_ext, fill_ones, region_off, overlay_on};
        exp_v = expect_out();
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s addr=%h act=%h exp=%h", tag, req_addr, act, exp_v);
        end
    endtask

    task automatic step(bit v, logic [31:0] a, logic [1:0] sz, bit w, logic [7:0] d, string tag);
        @(negedge clk);
        req_valid = v; req_addr = a; req_size = sz; req_write = w; req_wdata = d;
        #5 compare(tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_2345;
        step(0, 0, 0, 0, 0, "R1 reset state");
        @(negedge clk) rst_n = 1'b1;
        step(0, 32'h10, 0, 0, 0, "R11 idle");
        step(1, 32'h0, 2, 0, 0, "R4 read zero");
        step(1, 32'h1234, 1, 0, 0, "R4 read low");
        step(1, 32'h7FFFE, 0, 0, 0, "R4 last low");
        step(1, 32'h7FFFF, 0, 0, 0, "R4 excluded bound");
        step(1, 32'h100, 1, 1, 0, "R9 write low rom");
        step(1, 32'hBFE001, 1, 1, 8'h00, "R2 word write ignored");
        step(1, 32'hBFE001, 2, 1, 8'h00, "R2 long write ignored");
        step(1, 32'hBFE001, 0, 1, 8'hFE, "R3 ctrl write ext");
        step(1, 32'h0, 0, 0, 0, "R2 overlay cleared");
        step(1, 32'h0, 0, 0, 0, "R5 low goes ext");
        step(1, 32'hF7FFFF, 0, 0, 0, "R5 below high");
        step(1, 32'hF80000, 0, 0, 0, "R5 high base");
        step(1, 32'hFABCDE, 1, 0, 0, "R5 high mid");
        step(1, 32'hFFFFFE, 0, 0, 0, "R5 high top");
        step(1, 32'hFFFFFF, 0, 0, 0, "R10 top unmatched read");
        step(1, 32'hF80010, 1, 1, 0, "R9 write high rom");
        step(1, 32'hD80000, 1, 0, 0, "R6 low bound");
        step(1, 32'hD80001, 0, 0, 0, "R6 first");
        step(1, 32'hDEFFFE, 1, 1, 0, "R6 last");
        step(1, 32'hDEFFFF, 0, 0, 0, "R6 high bound");
        step(1, 32'h07FFFFFF, 0, 0, 0, "R7 base unmatched");
        step(1, 32'h08000000, 2, 0, 0, "R7 first ram");
        step(1, 32'hFFFFFFFF, 0, 1, 0, "R7 top ram");
        step(1, 32'h01000000, 0, 0, 0, "R10 gap read");
        step(1, 32'h02000000, 0, 1, 0, "R10 gap write");
        step(1, 32'hBFE001, 0, 1, 8'h01, "R3 ctrl write set");
        step(1, 32'h10, 1, 0, 0, "R2 overlay set again");
        step(1, 32'hBFE001, 0, 0, 8'h00, "R2 read ignored");
        step(1, 32'h10, 1, 0, 0, "R2 after read");
        step(1, 32'hBFE001, 0, 1, 8'h00, "R2 clear");
        @(negedge clk) rst_n = 1'b0;
        step(0, 0, 0, 0, 0, "R1 mid reset");
        @(negedge clk) rst_n = 1'b1;
        step(1, 32'h20, 0, 0, 0, "R1 mirror after reset");
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[3:1])
                3'd0: a = 32'hBFE001;
                3'd1: a = {8'h00, lfsr[31:8]};
                3'd2: a = {13'h0, lfsr[31:13]};
                3'd3: a = 32'hD80000 + {24'h0, lfsr[15:8]} - 32'd8;
                default: a = lfsr;
            endcase
            step(lfsr[4] | lfsr[9], a, lfsr[6:5], lfsr[7], lfsr[23:16], "R8 mixed");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule